// File: doc/BRIEF.md
# Distributed Arithmetic LUT Initializer

This block prepares the partial-sum tables of a distributed-arithmetic FIR filter at start-up. The taps are split into groups of `K`. Each group owns a table of `2^K` words. The word at entry `a` is the sum of the group's coefficients whose position bit is set in `a`. The coefficients are loaded at run time, so the tables live in writable RAM and must be built after every reset.

After reset the block waits for the coefficient buffer to report that all coefficients are present. One adder then walks through every table in turn and writes one word per cycle into the table RAM. Each new word is built from a word computed earlier in the same table plus one coefficient. Once the final word has been written, the block raises a ready flag. That flag tells the filter datapath that it may start taking samples. A second "loaded" indication is ignored until the next reset.

Top module: `da_lut_init`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `lut_we` and `filter_ready` are both 0.
- R2: Nothing is written until `coefs_loaded` has been seen high at a rising edge. The first write strobe appears on the second rising edge after that sample, one cycle of latency.
- R3: Entry 0 of every table is written with the value 0.
- R4: Entry `a` of table `t` equals the sum of coefficients `t*K+i` over every bit `i` set in `a`. Tap indices at or above `NTAPS` contribute zero. Coefficient `j` sits in bits `[j*CW +: CW]` of `coef_bus` as a two's-complement number.
- R5: Table words are `CW + clog2(K)` bits wide, two's complement, and the coefficients are sign-extended before they are summed.
- R6: The write address is `{table, entry}`, with the table index above the `K` entry bits. Exactly one strobe is issued per entry, on consecutive cycles. Tables are filled in ascending order, and entries within a table in ascending order. The total is `ceil(NTAPS/K) * 2^K` strobes.
- R7: All tables are filled by one shared adder, one table after another, with no gap between tables.
- R8: `filter_ready` stays low while any write is pending. It rises in the cycle right after the last write strobe, as `lut_we` falls, and it then stays high.
- R9: A `coefs_loaded` pulse that arrives during the fill or after `filter_ready` has risen causes no write and does not change `filter_ready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| coefs_loaded | input | 1 | Coefficient buffer holds all coefficients |
| coef_bus | input | NTAPS*CW | Buffered coefficients, tap j at bits [j*CW +: CW] |
| lut_we | output | 1 | Table RAM write strobe |
| lut_addr | output | TW+K | Table RAM address {table, entry} |
| lut_wdata | output | CW+clog2(K) | Table RAM write data |
| filter_ready | output | 1 | All tables written; filter may accept samples |

## Verification
Two events can fall into the same cycle: a new `coefs_loaded` pulse, and the final table write that immediately precedes `filter_ready` rising. The bench provokes this by raising `coefs_loaded` at the very cycle in which the last strobe is seen. Another run pulses it in the middle of the fill. Both cases are judged at the ports:
- the write count must stay exactly one full set;
- the address sequence must not restart;
- `filter_ready` must rise on schedule and remain high while further pulses arrive.

// File: rtl/da_lut_pkg.sv
package da_lut_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FILL  = 2'd1,
      ST_FLUSH = 2'd2,
      ST_DONE  = 2'd3
   } init_state_e;
endpackage

// File: rtl/da_lut_seq.sv
module da_lut_seq
   import da_lut_pkg::*;
#(
   parameter int K       = 4,
   parameter int NTABLES = 3,
   parameter int TW      = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          step,
   output logic [TW-1:0] tbl,
   output logic [K-1:0]  ent,
   output logic          ready
);
   localparam logic [TW-1:0] LAST_TBL = TW'(NTABLES - 1);
   localparam logic [K-1:0]  LAST_ENT = {K{1'b1}};

   init_state_e state;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         tbl   <= '0;
         ent   <= '0;
         ready <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start) begin
                  state <= ST_FILL;
                  tbl   <= '0;
                  ent   <= '0;
               end
            end
            ST_FILL: begin
               if (ent == LAST_ENT) begin
                  ent <= '0;
                  if (tbl == LAST_TBL) state <= ST_FLUSH;
                  else                 tbl   <= tbl + 1'b1;
               end else begin
                  ent <= ent + 1'b1;
               end
            end
            ST_FLUSH: begin
               ready <= 1'b1;
               state <= ST_DONE;
            end
            default: state <= ST_DONE;
         endcase
      end
   end

   assign step = (state == ST_FILL);
endmodule

// File: rtl/da_lut_engine.sv
module da_lut_engine #(
   parameter int K       = 4,
   parameter int CW      = 10,
   parameter int NTAPS   = 10,
   parameter int NTABLES = 3,
   parameter int TW      = 2,
   parameter int WW      = 12
) (
   input  logic                clk,
   input  logic                step,
   input  logic [TW-1:0]       tbl,
   input  logic [K-1:0]        ent,
   input  logic [NTAPS*CW-1:0] coef_bus,
   output logic [WW-1:0]       word
);
   localparam int ENTRIES = 1 << K;
   localparam int NPAD    = NTABLES * K;
   localparam int SW      = (NPAD > 1) ? $clog2(NPAD) : 1;

   logic signed [WW-1:0] cx [NPAD];
   logic [WW-1:0]        loc [ENTRIES];
   logic [K-1:0]         base;
   logic [SW-1:0]        sel;
   int                   hb;

   // Sign-extended coefficient array, padded with zero taps.
   for (genvar g = 0; g < NPAD; g++) begin : g_coef
      if (g < NTAPS) begin : g_real
         assign cx[g] = WW'($signed(coef_bus[g*CW +: CW]));
      end else begin : g_pad
         assign cx[g] = '0;
      end
   end

   // Highest set bit of the entry index and the entry it builds on.
   always_comb begin
      hb = 0;
      for (int i = 0; i < K; i++)
         if (ent[i]) hb = i;
      base = ent;
      for (int i = 0; i < K; i++)
         if (i == hb) base[i] = 1'b0;
      sel = SW'(int'(tbl) * K + hb);
   end

   assign word = (ent == '0) ? '0 : loc[base] + cx[sel];

   // Local copy of the table being built.
   always_ff @(posedge clk) begin
      if (step) loc[ent] <= word;
   end
endmodule

// File: rtl/da_lut_init.sv
module da_lut_init #(
   parameter int NTAPS = 10,
   parameter int K     = 4,
   parameter int CW    = 10,
   localparam int NTABLES = (NTAPS + K - 1) / K,
   localparam int GUARD   = $clog2(K),
   localparam int WW      = CW + GUARD,
   localparam int TW      = (NTABLES > 1) ? $clog2(NTABLES) : 1,
   localparam int AW      = TW + K
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                coefs_loaded,
   input  logic [NTAPS*CW-1:0] coef_bus,
   output logic                lut_we,
   output logic [AW-1:0]       lut_addr,
   output logic [WW-1:0]       lut_wdata,
   output logic                filter_ready
);
   if (K < 1 || K > 8) begin : g_bad_k
      $error("da_lut_init: K must lie in 1..8");
   end
   if (NTAPS < 1) begin : g_bad_taps
      $error("da_lut_init: NTAPS must be at least 1");
   end
   if (CW < 2) begin : g_bad_cw
      $error("da_lut_init: CW must be at least 2");
   end

   logic          step;
   logic [TW-1:0] tbl;
   logic [K-1:0]  ent;
   logic [WW-1:0] word;

   da_lut_seq #(.K(K), .NTABLES(NTABLES), .TW(TW)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (coefs_loaded),
      .step  (step),
      .tbl   (tbl),
      .ent   (ent),
      .ready (filter_ready)
   );

   da_lut_engine #(
      .K(K), .CW(CW), .NTAPS(NTAPS), .NTABLES(NTABLES), .TW(TW), .WW(WW)
   ) u_eng (
      .clk      (clk),
      .step     (step),
      .tbl      (tbl),
      .ent      (ent),
      .coef_bus (coef_bus),
      .word     (word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lut_we    <= 1'b0;
         lut_addr  <= '0;
         lut_wdata <= '0;
      end else begin
         lut_we <= step;
         if (step) begin
            lut_addr  <= {tbl, ent};
            lut_wdata <= word;
         end
      end
   end
endmodule

// File: rtl/da_lut_init_chk.sv
module da_lut_init_chk #(
   parameter int AW = 6,
   parameter int K  = 4,
   parameter int WW = 12
) (
   input logic          clk,
   input logic          rst_n,
   input logic          coefs_loaded,
   input logic          lut_we,
   input logic [AW-1:0] lut_addr,
   input logic [WW-1:0] lut_wdata,
   input logic          filter_ready
);
   // R8
   we_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lut_we |-> !filter_ready);

   // R8
   ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      filter_ready |=> filter_ready);

   // R8
   ready_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(filter_ready) |-> ($past(lut_we) && !lut_we));

   // R6
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lut_we && $past(lut_we)) |-> (lut_addr == AW'($past(lut_addr) + 1'b1)));

   // R6
   first_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lut_we) |-> (lut_addr == '0));

   // R3
   entry_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lut_we && lut_addr[K-1:0] == '0) |-> (lut_wdata == '0));

   // R9
   late_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (filter_ready && coefs_loaded) |=> !lut_we);
endmodule

bind da_lut_init da_lut_init_chk #(.AW(AW), .K(K), .WW(WW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .coefs_loaded (coefs_loaded),
   .lut_we       (lut_we),
   .lut_addr     (lut_addr),
   .lut_wdata    (lut_wdata),
   .filter_ready (filter_ready)
);

// File: tb/da_lut_init_test.sv
module da_lut_init_test;
   localparam int CLK_PERIOD = 10;
   localparam int NTAPS   = 10;
   localparam int K       = 4;
   localparam int CW      = 10;
   localparam int NTABLES = (NTAPS + K - 1) / K;
   localparam int WW      = CW + $clog2(K);
   localparam int TW      = (NTABLES > 1) ? $clog2(NTABLES) : 1;
   localparam int AW      = TW + K;
   localparam int ENT     = 1 << K;
   localparam int TOTAL   = NTABLES * ENT;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                coefs_loaded = 1'b0;
   logic [NTAPS*CW-1:0] coef_bus = '0;
   logic                lut_we;
   logic [AW-1:0]       lut_addr;
   logic [WW-1:0]       lut_wdata;
   logic                filter_ready;

   int          coefs [NTAPS];
   logic [WW-1:0] mem [TOTAL];
   int          n_checks = 0;
   int          n_err = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   da_lut_init #(.NTAPS(NTAPS), .K(K), .CW(CW)) uut (
      .clk(clk), .rst_n(rst_n), .coefs_loaded(coefs_loaded), .coef_bus(coef_bus),
      .lut_we(lut_we), .lut_addr(lut_addr), .lut_wdata(lut_wdata),
      .filter_ready(filter_ready)
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic logic [WW-1:0] exp_word(input int addr);
      int t = addr / ENT;
      int a = addr % ENT;
      int s = 0;
      for (int i = 0; i < K; i++)
         if (((a >> i) & 1) != 0 && t*K + i < NTAPS) s += coefs[t*K + i];
      return WW'(s);
   endfunction

   // kind: 0 all most-negative, 1 all most-positive, 2 alternating, else random
   task automatic load_coefs(input int kind);
      for (int j = 0; j < NTAPS; j++) begin
         case (kind)
            0: coefs[j] = -(1 << (CW-1));
            1: coefs[j] = (1 << (CW-1)) - 1;
            2: coefs[j] = (j % 2 == 0) ? (1 << (CW-1)) - 1 : -(1 << (CW-1));
            default: coefs[j] = int'($urandom_range(0, (1 << CW) - 1)) - (1 << (CW-1));
         endcase
         coef_bus[j*CW +: CW] = CW'(coefs[j]);
      end
   endtask

   task automatic run_round(input int kind, input bit mid_pulse, input bit end_pulse);
      int  n_wr = 0;
      bit  prev_we = 0;
      bit  done = 0;
      load_coefs(kind);
      for (int a = 0; a < TOTAL; a++) mem[a] = '1;
      rst_n = 1'b0;
      coefs_loaded = 1'b0;
      repeat (3) @(negedge clk);
      // R1: outputs quiet during reset
      check(!lut_we && !filter_ready, "R1 reset", {lut_we, filter_ready}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!lut_we && !filter_ready, "R1 after reset", {lut_we, filter_ready}, 0);
      repeat (4) begin
         @(negedge clk);
         // R2: idle without coefs_loaded
         check(!lut_we && !filter_ready, "R2 idle", {lut_we, filter_ready}, 0);
      end
      coefs_loaded = 1'b1;
      @(negedge clk);
      coefs_loaded = 1'b0;
      for (int i = 0; i < 4 * TOTAL && !done; i++) begin
         if (i > 0) @(negedge clk);
         coefs_loaded = 1'b0;
         if (lut_we) begin
            n_wr++;
            // R2: first strobe one cycle after the start was sampled
            if (n_wr == 1) check(i == 1, "R2 latency", i, 1);
            // R6, R7: consecutive addresses, table-major
            check(int'(lut_addr) == n_wr - 1, "R6 addr", lut_addr, n_wr - 1);
            // R4, R3: word value
            check(lut_wdata == exp_word(n_wr - 1), "R4 data", lut_wdata, exp_word(n_wr - 1));
            check(!filter_ready, "R8 ready low in fill", filter_ready, 0);
            if (int'(lut_addr) < TOTAL) mem[lut_addr] = lut_wdata;
            if (mid_pulse && n_wr == TOTAL/2) coefs_loaded = 1'b1;
            // R9: pulse in the cycle of the last write
            if (end_pulse && n_wr == TOTAL) coefs_loaded = 1'b1;
         end else if (i > 1 && !filter_ready) begin
            check(0, "R7 gap in fill", i, -1);
         end
         if (filter_ready) begin
            done = 1;
            check(prev_we && !lut_we, "R8 ready timing", {prev_we, lut_we}, 2);
            check(n_wr == TOTAL, "R6 write count", n_wr, TOTAL);
         end
         prev_we = lut_we;
      end
      check(done, "R8 ready never rose", done, 1);
      coefs_loaded = 1'b0;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         // R9: late pulses ignored
         check(!lut_we && filter_ready, "R9 ignore", {lut_we, filter_ready}, 1);
         coefs_loaded = (i % 3 == 0);
      end
      coefs_loaded = 1'b0;
      for (int a = 0; a < TOTAL; a++) begin
         // R4, R3, R5: stored table contents
         check(mem[a] == exp_word(a), "R4 table", mem[a], exp_word(a));
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_checks + 1, n_err + 1);
      $finish;
   end

   initial begin
      void'($urandom(32'd20211));
      // R5: word width
      check($bits(lut_wdata) == CW + $clog2(K), "R5 width", $bits(lut_wdata), CW + $clog2(K));
      run_round(0, 0, 1);
      run_round(1, 1, 0);
      run_round(2, 1, 1);
      for (int r = 0; r < 5; r++) run_round(3, r[0], ~r[0]);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end
endmodule